// File: doc/BRIEF.md
# Scalable Word-Serial Montgomery Multiplier

This block computes a radix-2 Montgomery product S = X·Y·2^(-K) mod M, with K = W·E. The operands are split into E words of W bits. Y and M stream through a chain of N processing elements at one word per clock, least significant word first. Each element applies one bit of X to the running partial sum, so one trip through the chain consumes N bits of X. The partial sum leaving the last element is written into a dual-port scratch memory. While later words are still being written, earlier words of the next trip are read back out of the same memory. This lets a short chain handle any number of X bits.

A host drives a simple strobe-based register port. It writes the X, Y and M words, then writes the start bit. It polls the status word until done is set, and then reads the result words. The controller pulses a load enable into each element when that element's first word of a trip arrives, together with the X bit for that element and trip. These enables sit two cycles apart along the chain. Elaboration stops if N does not divide E or if E is less than 2.

Top module: `mmx_mont_mul`

## Requirements
- R1: For odd M < 2^(K-1) and Y < M, the result region holds the value of the radix-2 recurrence s ← (s + x_i·Y + q·M)/2, taken over all K bits of X from i = 0 upward, where q is the low bit of s + x_i·Y and s starts at 0. This value is congruent to X·Y·2^(-K) mod M and is below 2M.
- R2: After reset, the status word at region 0 offset 1 reads 0. In that word, bit 0 is busy and bit 1 is done.
- R3: The host address is split into a region field (top 3 bits) and a word offset (low log2(E) bits). Region 1 is X, 2 is Y, 3 is M and 4 is the result, with word 0 the least significant. Operand words read back what was written. Host writes to the result region leave it unchanged. The control word at region 0 offset 0 reads as 0.
- R4: Busy and done are never set together. Busy stays set from the cycle after an accepted start until the operation completes.
- R5: An operation stays busy for exactly (P−1)·G + E + 2N + 1 cycles, where P = K/N and G = max(E, 2N+2).
- R6: Done remains set until the next accepted start. In the cycle after that start, status shows busy=1 and done=0.
- R7: A start written while busy is ignored. The completion time and the result are those of the operation already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | log2(E)+3 | Region (top 3 bits) and word offset |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Read data for host_addr (combinational) |

## Verification
The bench targets several corner cases, each of which a faulty design would expose:
- X = 0 and X all ones. A wrong quotient bit or a wrong carry between words shows up here as a nonzero or shifted result.
- The largest allowed modulus with Y = M−1. This drives the partial sum close to 2M and exposes a lost top carry bit in the last word of each trip.
- Many moduli with mixed operands. A slip in recirculation timing makes the next trip read a stale word, which corrupts the result.
- An exact completion count. This catches any extra or missing trip, or a wrong pass gap.
- A start issued in the middle of a run. A design that accepted it would restart and finish late with the wrong count.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  typedef enum logic [2:0] {
    RG_CSR = 3'd0,
    RG_X   = 3'd1,
    RG_Y   = 3'd2,
    RG_M   = 3'd3,
    RG_S   = 3'd4
  } region_e;

  localparam int unsigned CSR_CTRL = 0;
  localparam int unsigned CSR_STAT = 1;

  // cycles between trip starts: wide enough for the chain to drain
  function automatic int unsigned trip_gap(input int unsigned e, input int unsigned n);
    return (e > 2 * n + 2) ? e : 2 * n + 2;
  endfunction

endpackage

// File: rtl/mmx_pe.sv
module mmx_pe #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         in_first,
  input  logic         in_last,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_m,
  input  logic [W-1:0] in_s,
  input  logic         x_ld,
  input  logic         x_in,
  output logic         out_vld,
  output logic         out_first,
  output logic         out_last,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_m,
  output logic [W-1:0] out_s
);
  localparam int unsigned SW = W + 2;

  logic         x_q, q_q, f_q, pend_q;
  logic [1:0]   c_q;
  logic [W-1:0] w_q, y1_q, m1_q;

  logic         x_cur, q_cur, emit_mid;
  logic [W-1:0] xy, addm;
  logic [1:0]   cin;
  logic [SW-1:0] sum;
  logic         x_d, q_d, f_d, pend_d, ov_d, of_d, ol_d;
  logic [1:0]   c_d;
  logic [W-1:0] w_d, os_d;

  always_comb begin
    x_cur    = x_ld ? x_in : x_q;
    xy       = x_cur ? in_y : '0;
    q_cur    = in_first ? (in_s[0] ^ xy[0]) : q_q;
    addm     = q_cur ? in_m : '0;
    cin      = in_first ? 2'b00 : c_q;
    sum      = {2'b00, in_s} + {2'b00, xy} + {2'b00, addm} + {{W{1'b0}}, cin};
    emit_mid = in_vld & ~in_first;
    x_d      = x_cur;
    q_d      = in_vld ? q_cur : q_q;
    c_d      = in_vld ? sum[W+1:W] : c_q;
    w_d      = in_vld ? sum[W-1:0] : w_q;
    f_d      = in_vld ? in_first : f_q;
    pend_d   = in_vld & in_last;
    ov_d     = emit_mid | pend_q;
    of_d     = emit_mid & f_q;
    ol_d     = pend_q;
    os_d     = pend_q ? {c_q[0], w_q[W-1:1]} : {sum[0], w_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= 1'b0; q_q <= 1'b0; f_q <= 1'b0; pend_q <= 1'b0;
      c_q <= '0; w_q <= '0; y1_q <= '0; m1_q <= '0;
      out_vld <= 1'b0; out_first <= 1'b0; out_last <= 1'b0;
      out_y <= '0; out_m <= '0; out_s <= '0;
    end else begin
      x_q <= x_d; q_q <= q_d; f_q <= f_d; pend_q <= pend_d;
      c_q <= c_d; w_q <= w_d; y1_q <= in_y; m1_q <= in_m;
      out_vld <= ov_d; out_first <= of_d; out_last <= ol_d;
      out_y <= y1_q; out_m <= m1_q; out_s <= os_d;
    end
  end

  // R1
  top_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !c_q[1]);
  // R1
  tail_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !(in_vld && !in_first));

endmodule

// File: rtl/mmx_ctrl.sv
module mmx_ctrl #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2,
  parameter int unsigned E = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  fin_last,
  output logic                  busy,
  output logic                  done,
  output logic                  rd_en,
  output logic [$clog2(E)-1:0]  rd_addr,
  output logic                  rd_first,
  output logic                  rd_last,
  output logic                  rd_zero,
  output logic [N-1:0]          x_ld,
  output logic [N-1:0][$clog2(E*W)-1:0] x_idx
);
  localparam int unsigned P  = E * W / N;
  localparam int unsigned SP = mmx_pkg::trip_gap(E, N);
  localparam int unsigned LW = $clog2(E);
  localparam int unsigned CW = $clog2(SP);
  localparam int unsigned PW = $clog2(P + 1);
  localparam int unsigned IW = $clog2(E * W);
  localparam int unsigned D  = 2 * N - 1;

  logic          run_q, done_q, run_d, done_d;
  logic [PW-1:0] pass_q, pass_d, fin_q, fin_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [D-1:0]  tok_q, tok_d;
  logic [D-1:0][PW-1:0] pdl_q, pdl_d;
  logic          issuing, wrap;

  always_comb begin
    issuing  = run_q && (pass_q < PW'(P));
    wrap     = (cyc_q == CW'(SP - 1));
    rd_en    = issuing && (cyc_q < CW'(E));
    rd_addr  = cyc_q[LW-1:0];
    rd_first = (cyc_q == '0);
    rd_last  = (cyc_q == CW'(E - 1));
    rd_zero  = (pass_q == '0);
    run_d = run_q; done_d = done_q; pass_d = pass_q; cyc_d = cyc_q; fin_d = fin_q;
    if (go && !run_q) begin
      run_d = 1'b1; done_d = 1'b0; pass_d = '0; cyc_d = '0; fin_d = '0;
    end else if (run_q) begin
      if (issuing) begin
        cyc_d  = wrap ? '0 : cyc_q + 1'b1;
        pass_d = wrap ? pass_q + 1'b1 : pass_q;
      end
      if (fin_last) begin
        fin_d = fin_q + 1'b1;
        if (fin_q == PW'(P - 1)) begin
          run_d = 1'b0; done_d = 1'b1;
        end
      end
    end
    tok_d[0] = rd_en & rd_first;
    pdl_d[0] = pass_q;
    for (int d = 1; d < int'(D); d++) begin
      tok_d[d] = tok_q[d-1];
      pdl_d[d] = pdl_q[d-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; pass_q <= '0; cyc_q <= '0; fin_q <= '0;
      tok_q <= '0; pdl_q <= '0;
    end else begin
      run_q <= run_d; done_q <= done_d; pass_q <= pass_d; cyc_q <= cyc_d; fin_q <= fin_d;
      tok_q <= tok_d; pdl_q <= pdl_d;
    end
  end

  assign busy = run_q;
  assign done = done_q;

  for (genvar s = 0; s < int'(N); s++) begin : g_xsel
    assign x_ld[s]  = tok_q[2*s];
    assign x_idx[s] = IW'(32'(pdl_q[2*s]) * N + s);
  end

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && done_q));
  // R4
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(go));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !go) |=> done_q);
  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && go && pass_q != '0) |=> (pass_q != '0));

endmodule

// File: rtl/mmx_store.sv
module mmx_store #(
  parameter int unsigned W = 8,
  parameter int unsigned E = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   h_we,
  input  logic [$clog2(E)+2:0]   h_addr,
  input  logic [W-1:0]           h_wdata,
  output logic [W-1:0]           h_rdata,
  input  logic                   busy,
  input  logic                   done,
  output logic                   go,
  input  logic                   rd_en,
  input  logic [$clog2(E)-1:0]   rd_addr,
  input  logic                   rd_first,
  input  logic                   rd_last,
  input  logic                   rd_zero,
  output logic                   s0_vld,
  output logic                   s0_first,
  output logic                   s0_last,
  output logic [W-1:0]           s0_y,
  output logic [W-1:0]           s0_m,
  output logic [W-1:0]           s0_s,
  input  logic                   fin_vld,
  input  logic                   fin_first,
  input  logic [W-1:0]           fin_s,
  output logic [E*W-1:0]         x_all
);
  import mmx_pkg::*;
  localparam int unsigned LW = $clog2(E);
  localparam int unsigned AW = LW + 3;

  logic [E-1:0][W-1:0] xm, ym, mm, sm;
  logic [2:0]    region;
  logic [LW-1:0] off, wa, wq_q, wq_d;
  logic          off_ok;

  assign region = h_addr[AW-1:LW];
  assign off    = h_addr[LW-1:0];
  assign off_ok = 32'(off) < E;
  assign go     = h_we && region == RG_CSR && off == LW'(CSR_CTRL) && h_wdata[0];
  assign x_all  = xm;
  assign wa     = fin_first ? '0 : wq_q;
  assign wq_d   = fin_vld ? wa + 1'b1 : wq_q;

  always_comb begin
    h_rdata = '0;
    if (off_ok) begin
      unique case (region)
        RG_CSR:  if (off == LW'(CSR_STAT)) h_rdata[1:0] = {done, busy};
        RG_X:    h_rdata = xm[off];
        RG_Y:    h_rdata = ym[off];
        RG_M:    h_rdata = mm[off];
        RG_S:    h_rdata = sm[off];
        default: h_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (h_we && off_ok) begin
      if (region == RG_X) xm[off] <= h_wdata;
      if (region == RG_Y) ym[off] <= h_wdata;
      if (region == RG_M) mm[off] <= h_wdata;
    end
  end

  // scratch sum: read port and write port active in the same cycle
  always_ff @(posedge clk) begin
    if (fin_vld) sm[wa] <= fin_s;
    if (rd_en) begin
      s0_y <= ym[rd_addr];
      s0_m <= mm[rd_addr];
      s0_s <= rd_zero ? '0 : sm[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_vld <= 1'b0; s0_first <= 1'b0; s0_last <= 1'b0; wq_q <= '0;
    end else begin
      s0_vld <= rd_en; s0_first <= rd_en & rd_first; s0_last <= rd_en & rd_last;
      wq_q <= wq_d;
    end
  end

  // R1
  writeback_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_vld && !fin_first) |-> $past(fin_vld));

endmodule

// File: rtl/mmx_mont_mul.sv
module mmx_mont_mul #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2,
  parameter int unsigned E = 4,
  localparam int unsigned AW = $clog2(E) + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata
);
  localparam int unsigned LW = $clog2(E);
  localparam int unsigned IW = $clog2(E * W);

  if ((E % N) != 0 || E < 2) begin : g_bad_cfg
    $error("stage count must divide word count, and word count must be at least 2");
  end

  logic              busy, done, go, rd_en, rd_first, rd_last, rd_zero;
  logic [LW-1:0]     rd_addr;
  logic [N-1:0]      x_ld, x_bit;
  logic [N-1:0][IW-1:0] x_idx;
  logic [E*W-1:0]    x_all;
  logic [N:0]        sv, sf, sl;
  logic [N:0][W-1:0] sy, smd, ss;

  mmx_ctrl #(.W(W), .N(N), .E(E)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .fin_last(sv[N] & sl[N]),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_first(rd_first), .rd_last(rd_last), .rd_zero(rd_zero),
    .x_ld(x_ld), .x_idx(x_idx)
  );

  mmx_store #(.W(W), .E(E)) u_store (
    .clk(clk), .rst_n(rst_n), .h_we(host_we), .h_addr(host_addr),
    .h_wdata(host_wdata), .h_rdata(host_rdata), .busy(busy), .done(done), .go(go),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_first(rd_first), .rd_last(rd_last),
    .rd_zero(rd_zero), .s0_vld(sv[0]), .s0_first(sf[0]), .s0_last(sl[0]),
    .s0_y(sy[0]), .s0_m(smd[0]), .s0_s(ss[0]),
    .fin_vld(sv[N]), .fin_first(sf[N]), .fin_s(ss[N]), .x_all(x_all)
  );

  for (genvar s = 0; s < int'(N); s++) begin : g_stage
    assign x_bit[s] = x_all[x_idx[s]];
    mmx_pe #(.W(W)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(sv[s]), .in_first(sf[s]), .in_last(sl[s]),
      .in_y(sy[s]), .in_m(smd[s]), .in_s(ss[s]),
      .x_ld(x_ld[s]), .x_in(x_bit[s]),
      .out_vld(sv[s+1]), .out_first(sf[s+1]), .out_last(sl[s+1]),
      .out_y(sy[s+1]), .out_m(smd[s+1]), .out_s(ss[s+1])
    );
  end

  // R1
  chain_first_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sv[N] && sf[N]) |-> !sl[N]);

endmodule

// File: tb/mmx_mont_mul_test.sv
module mmx_mont_mul_test;
  localparam int W = 4;
  localparam int N = 2;
  localparam int E = 4;
  localparam int K = W * E;
  localparam int LW = 2;
  localparam int AW = LW + 3;
  localparam int P = K / N;
  localparam int G = (E > 2 * N + 2) ? E : 2 * N + 2;
  localparam int LAT = (P - 1) * G + E + 2 * N + 1;

  logic clk, rst_n, host_we;
  logic [AW-1:0] host_addr;
  logic [W-1:0] host_wdata, host_rdata;
  int total = 0;
  int bad = 0;
  int unsigned seed = 32'h1234_5678;

  mmx_mont_mul #(.W(W), .N(N), .E(E)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [AW-1:0] adr(input int region, input int off);
    return {3'(region), LW'(off)};
  endfunction

  function automatic logic [15:0] ref_mm(input logic [15:0] x, input logic [15:0] y,
                                         input logic [15:0] m);
    logic [17:0] s;
    s = '0;
    for (int i = 0; i < K; i++) begin
      s = s + (x[i] ? {2'b00, y} : 18'd0);
      if (s[0]) s = s + {2'b00, m};
      s = s >> 1;
    end
    return s[15:0];
  endfunction

  function automatic int unsigned nxt(inout int unsigned st);
    st = st * 32'd1664525 + 32'd1013904223;
    return st >> 8;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int region, input int off, input logic [W-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = adr(region, off); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int region, input int off, output logic [W-1:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = adr(region, off);
    #1 d = host_rdata;
  endtask

  task automatic load16(input int region, input logic [15:0] v);
    for (int j = 0; j < E; j++) wr(region, j, v[j*W +: W]);
  endtask

  task automatic read16(input int region, output logic [15:0] v);
    logic [W-1:0] d;
    for (int j = 0; j < E; j++) begin
      rd(region, j, d);
      v[j*W +: W] = d;
    end
  endtask

  task automatic run_op(input int restart_at, output int busy_cyc);
    logic [W-1:0] st;
    bit fin;
    busy_cyc = 0;
    fin = 1'b0;
    @(negedge clk);
    host_we = 1'b1; host_addr = adr(0, 0); host_wdata = 1;
    @(negedge clk);
    host_we = 1'b0; host_addr = adr(0, 1);
    for (int i = 0; i < 1000 && !fin; i++) begin
      #1 st = host_rdata;
      if (i == 0) chk(st[1:0] == 2'b01, "R6 status after start", st, 1);
      if (st[1:0] == 2'b11) chk(1'b0, "R4 busy and done together", st, 1);
      if (st[0]) begin
        busy_cyc++;
        if (i == restart_at) begin
          host_we = 1'b1; host_addr = adr(0, 0); host_wdata = 1;
          @(negedge clk);
          host_we = 1'b0; host_addr = adr(0, 1);
        end else begin
          @(negedge clk);
        end
      end else begin
        chk(st[1:0] == 2'b10, "R4 done at completion", st, 2);
        fin = 1'b1;
      end
    end
  endtask

  task automatic one_case(input logic [15:0] x, input logic [15:0] y,
                          input logic [15:0] m, input int restart_at);
    int cyc;
    logic [15:0] res, exp;
    load16(1, x); load16(2, y); load16(3, m);
    run_op(restart_at, cyc);
    chk(cyc == LAT, restart_at >= 0 ? "R7 latency with restart" : "R5 latency", cyc, LAT);
    exp = ref_mm(x, y, m);
    read16(4, res);
    chk(res == exp, restart_at >= 0 ? "R7 result with restart" : "R1 result", res, exp);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    logic [15:0] v, r0, r1;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset status
    rd(0, 1, d);
    chk(d == '0, "R2 reset status", d, 0);

    // R3 operand readback and control word
    load16(1, 16'hA5C3); load16(2, 16'h0F1E); load16(3, 16'h7001);
    read16(1, v); chk(v == 16'hA5C3, "R3 X readback", v, 16'hA5C3);
    read16(2, v); chk(v == 16'h0F1E, "R3 Y readback", v, 16'h0F1E);
    read16(3, v); chk(v == 16'h7001, "R3 M readback", v, 16'h7001);
    rd(0, 0, d); chk(d == '0, "R3 control reads zero", d, 0);

    // directed corners
    one_case(16'h0000, 16'h1234, 16'h7FFF, -1);
    one_case(16'hFFFF, 16'h7FFE, 16'h7FFF, -1);
    one_case(16'hFFFF, 16'h0002, 16'h0003, -1);
    one_case(16'h8001, 16'h0000, 16'h4321, -1);

    // R6 done held while idle
    repeat (5) @(negedge clk);
    rd(0, 1, d);
    chk(d == 4'b0010, "R6 done held", d, 2);

    // R3 result region ignores host writes
    read16(4, r0);
    load16(4, ~r0);
    read16(4, r1);
    chk(r1 == r0, "R3 result write ignored", r1, r0);

    // R7 start during run
    one_case(16'hBEEF, 16'h1357, 16'h6A4B, 10);

    // sweep over moduli and operands
    for (int mi = 0; mi < 24; mi++) begin
      logic [15:0] m;
      m = 16'(nxt(seed)) & 16'h7FFF;
      m[0] = 1'b1;
      if (m < 16'd3) m = 16'd3;
      for (int k = 0; k < 6; k++) begin
        logic [15:0] x, y;
        x = 16'(nxt(seed));
        y = 16'(nxt(seed) % m);
        one_case(x, y, m, -1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule